// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register file of a small processor core whose register set is banked by operating mode. It holds the architectural registers R0 to R14 as seen from four modes: user, fast interrupt, normal interrupt and supervisor. The fast-interrupt mode owns private copies of R8 to R14. The normal-interrupt and supervisor modes each own private copies of R13 and R14 only. Every other register is shared with user mode. R15 is held by the core's status logic, so this block reads it as zero and drops writes to it.

The core presents a mode code and a force-user bit every cycle, together with two read addresses and one write port. An address decoder turns each architectural index into a physical slot for the current mode. A mode change therefore needs no copying: the next read already sees the new bank, and the banks left behind keep their contents until their mode comes back. With force-user set, privileged code reaches the user copies of its own shadowed registers. Store-multiple and load-multiple sequences that work on user state use this path.

Top module: `regbank_file`

## Requirements
- R1: After reset every register in every bank reads as zero.
- R2: In user mode (mode code 2'b00), addresses 0 to 14 reach the user copies, with or without force-user.
- R3: In fast-interrupt mode (mode code 2'b01) without force-user, addresses 8 to 14 reach a private bank of seven registers, and addresses 0 to 7 reach the user copies.
- R4: In normal-interrupt mode (2'b10) and supervisor mode (2'b11) without force-user, addresses 13 and 14 reach a private two-register bank for that mode, and addresses 0 to 12 reach the user copies.
- R5: With force-user set in normal-interrupt or supervisor mode, reads and writes to addresses 13 and 14 reach the user copies.
- R6: With force-user set in fast-interrupt mode, reads and writes to addresses 8 to 14 reach the user copies.
- R7: A mode change alters no bank, so returning to a mode gives back the values it left behind.
- R8: Reads are combinational in the mode, force-user and address inputs, so a new mode shows in the read data during the cycle in which it is presented.
- R9: A write takes effect at the rising clock edge. A read of the same mapped register in the write's own cycle returns the old value, because there is no bypass.
- R10: Address 15 reads as zero on both ports, and a write to it changes no register.
- R11: The two read ports are independent and use the same mapping, so equal addresses return equal data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode: 00 user, 01 fast interrupt, 10 normal interrupt, 11 supervisor |
| force_user | input | 1 | Redirect shadowed addresses to the user copies |
| rd_a_addr | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_addr | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write architectural index |
| wr_data | input | DATA_W | Write data |

## Verification
The bench builds the block with its default width, DATA_W = 32. Every data pattern therefore uses the full word, and a slip in the top bits or a mix-up between banks shows up as a distinct value. The patterns tag each bank with its own high byte, so a value read through the wrong mapping is recognised at once. Directed phases walk every mode and force-user combination over the boundary addresses 7/8, 12/13, 14 and 15. A long pseudo-random phase then mixes mode changes, force-user and writes to the same address as a read in one cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  localparam int ARCH_W     = 4;
  localparam int USR_SLOTS  = 15;
  localparam int FIQ_SLOTS  = 7;
  localparam int PRIV_SLOTS = 2;
  localparam int FIQ_FIRST  = USR_SLOTS - FIQ_SLOTS;   // arch index 8
  localparam int PRIV_FIRST = USR_SLOTS - PRIV_SLOTS;  // arch index 13
  localparam int FIQ_BASE   = USR_SLOTS;
  localparam int IRQ_BASE   = FIQ_BASE + FIQ_SLOTS;
  localparam int SVC_BASE   = IRQ_BASE + PRIV_SLOTS;
  localparam int PHYS_REGS  = SVC_BASE + PRIV_SLOTS;
  localparam int NO_SLOT    = PHYS_REGS;
  localparam int PHYS_W     = $clog2(PHYS_REGS + 1);

  // Map an architectural index in a given mode onto a physical slot.
  function automatic logic [PHYS_W-1:0] map_slot(input cpu_mode_e m,
                                                 input logic fu,
                                                 input logic [ARCH_W-1:0] a);
    logic [PHYS_W-1:0] idx;
    idx = PHYS_W'(a);
    if (a == ARCH_W'(USR_SLOTS)) begin
      idx = PHYS_W'(NO_SLOT);
    end else if (!fu) begin
      case (m)
        MODE_FIQ: if (a >= ARCH_W'(FIQ_FIRST))
                    idx = PHYS_W'(FIQ_BASE) + PHYS_W'(a - ARCH_W'(FIQ_FIRST));
        MODE_IRQ: if (a >= ARCH_W'(PRIV_FIRST))
                    idx = PHYS_W'(IRQ_BASE) + PHYS_W'(a - ARCH_W'(PRIV_FIRST));
        MODE_SVC: if (a >= ARCH_W'(PRIV_FIRST))
                    idx = PHYS_W'(SVC_BASE) + PHYS_W'(a - ARCH_W'(PRIV_FIRST));
        default:  idx = PHYS_W'(a);
      endcase
    end
    return idx;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  cpu_mode_e          mode,
  input  logic               force_user,
  input  logic [ARCH_W-1:0]  arch_idx,
  output logic [PHYS_W-1:0]  slot
);
  always_comb slot = map_slot(mode, force_user, arch_idx);
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 26,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [SLOT_W-1:0]    rd_slot_a,
  input  logic [SLOT_W-1:0]    rd_slot_b,
  output logic [DATA_W-1:0]    rd_data_a,
  output logic [DATA_W-1:0]    rd_data_b,
  output logic [NUM_SLOTS-1:0] wr_strobe
);
  logic [DATA_W-1:0] slots [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign wr_strobe[g] = wr_en && (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)            slots[g] <= '0;
      else if (wr_strobe[g]) slots[g] <= wr_data;
    end
  end

  // Out-of-range slots (the R15 sentinel) select nothing and read zero.
  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_slot_a == SLOT_W'(i)) rd_data_a = slots[i];
      if (rd_slot_b == SLOT_W'(i)) rd_data_b = slots[i];
    end
  end
endmodule

// File: rtl/regbank_file.sv
module regbank_file
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              force_user,
  input  logic [3:0]        rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NUM_PORTS = 3;

  cpu_mode_e            cur_mode;
  logic [ARCH_W-1:0]    port_addr [NUM_PORTS];
  logic [PHYS_W-1:0]    port_slot [NUM_PORTS];
  logic [PHYS_W-1:0]    slot_rd_a, slot_rd_b, slot_wr;
  logic [PHYS_REGS-1:0] wr_strobe;

  assign cur_mode     = cpu_mode_e'(mode);
  assign port_addr[0] = rd_a_addr;
  assign port_addr[1] = rd_b_addr;
  assign port_addr[2] = wr_addr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    regbank_decode dec_i (
      .mode       (cur_mode),
      .force_user (force_user),
      .arch_idx   (port_addr[p]),
      .slot       (port_slot[p])
    );
  end

  assign slot_rd_a = port_slot[0];
  assign slot_rd_b = port_slot[1];
  assign slot_wr   = port_slot[2];

  regbank_store #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (PHYS_REGS),
    .SLOT_W    (PHYS_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_slot   (slot_wr),
    .wr_data   (wr_data),
    .rd_slot_a (slot_rd_a),
    .rd_slot_b (slot_rd_b),
    .rd_data_a (rd_a_data),
    .rd_data_b (rd_b_data),
    .wr_strobe (wr_strobe)
  );
endmodule

// File: rtl/regbank_file_chk.sv
module regbank_file_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 26,
  parameter int USR_CNT   = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 force_user,
  input logic [3:0]           rd_a_addr,
  input logic [DATA_W-1:0]    rd_a_data,
  input logic [3:0]           rd_b_addr,
  input logic [DATA_W-1:0]    rd_b_data,
  input logic                 wr_en,
  input logic [3:0]           wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_SLOTS-1:0] wr_strobe
);
  // R10
  r15_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 4'hF) |-> (rd_a_data == '0));

  // R10
  r15_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr == 4'hF) |-> (wr_strobe == '0));

  // R11
  ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

  // R9
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) == rd_a_addr && rd_a_addr != 4'hF
     && $stable(mode) && $stable(force_user)) |-> (rd_a_data == $past(wr_data)));

  // R7
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(mode) && $stable(force_user)
     && $stable(rd_b_addr)) |-> $stable(rd_b_data));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 4'hF) |-> ($countones(wr_strobe) == 1));

  // R3
  fiq_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'b01 && !force_user && wr_addr >= 4'd8 && wr_addr != 4'hF)
    |-> (wr_strobe[USR_CNT-1:0] == '0));

  // R5
  force_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && force_user && wr_addr != 4'hF) |-> wr_strobe[wr_addr]);
endmodule

bind regbank_file regbank_file_chk #(
  .DATA_W    (DATA_W),
  .NUM_SLOTS (regbank_pkg::PHYS_REGS),
  .USR_CNT   (regbank_pkg::USR_SLOTS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .force_user (force_user),
  .rd_a_addr  (rd_a_addr),
  .rd_a_data  (rd_a_data),
  .rd_b_addr  (rd_b_addr),
  .rd_b_data  (rd_b_data),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_strobe  (wr_strobe)
);

// File: tb/regbank_file_tb_top.sv
module regbank_file_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          force_user = 1'b0;
  logic [3:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  // Behavioural reference: one array per bank owner.
  logic [DW-1:0] usr_m [15];
  logic [DW-1:0] fiq_m [7];
  logic [DW-1:0] irq_m [2];
  logic [DW-1:0] svc_m [2];

  always #2 clk = ~clk;

  regbank_file #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .force_user(force_user),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] m_read(int m, bit fu, int a);
    if (a == 15) return '0;
    if (!fu && m == 1 && a >= 8)  return fiq_m[a-8];
    if (!fu && m == 2 && a >= 13) return irq_m[a-13];
    if (!fu && m == 3 && a >= 13) return svc_m[a-13];
    return usr_m[a];
  endfunction

  task automatic m_write(int m, bit fu, int a, logic [DW-1:0] d);
    if (a == 15) return;
    if (!fu && m == 1 && a >= 8)       fiq_m[a-8]  = d;
    else if (!fu && m == 2 && a >= 13) irq_m[a-13] = d;
    else if (!fu && m == 3 && a >= 13) svc_m[a-13] = d;
    else                               usr_m[a]    = d;
  endtask

  task automatic check(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s mode=%0d fu=%0b: got %h expected %h",
               tag, what, mode, force_user, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare reads before the write lands.
  task automatic cyc(string tag, int m, bit fu, int ra, int rb,
                     bit we, int wa, logic [DW-1:0] wd);
    mode = 2'(m); force_user = fu; rd_a_addr = 4'(ra); rd_b_addr = 4'(rb);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    #1;
    check(tag, $sformatf("portA r%0d", ra), rd_a_data, m_read(m, fu, ra));
    check(tag, $sformatf("portB r%0d", rb), rd_b_data, m_read(m, fu, rb));
    @(posedge clk);
    if (we) m_write(m, fu, wa, wd);
    @(negedge clk);
  endtask

  task automatic rd(string tag, int m, bit fu, int ra, int rb);
    cyc(tag, m, fu, ra, rb, 1'b0, 0, '0);
  endtask

  task automatic wr(string tag, int m, bit fu, int a, logic [DW-1:0] d);
    cyc(tag, m, fu, a, 15 - a, 1'b1, a, d);
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) usr_m[i] = '0;
    for (int i = 0; i < 7; i++)  fiq_m[i] = '0;
    for (int i = 0; i < 2; i++) begin irq_m[i] = '0; svc_m[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: every bank reads zero after reset
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++) rd("R1", m, 1'b0, a, a + 8);

    // R2: user mode writes and reads every user copy; force-user changes nothing
    for (int a = 0; a < 15; a++) wr("R2", 0, 1'b0, a, 32'hA000_0000 | 32'(a));
    for (int a = 0; a < 15; a++) rd("R2", 0, 1'b1, a, 14 - a);

    // R3: fast-interrupt private R8..R14, shared R0..R7
    rd("R3", 1, 1'b0, 7, 8);
    for (int a = 8; a < 15; a++) wr("R3", 1, 1'b0, a, 32'hF100_0000 | 32'(a));
    wr("R3", 1, 1'b0, 3, 32'hF1F1_0003);
    for (int a = 0; a < 15; a++) rd("R3", 1, 1'b0, a, a);
    rd("R3", 0, 1'b0, 3, 8);

    // R4: interrupt and supervisor private R13/R14, shared R0..R12
    wr("R4", 2, 1'b0, 13, 32'h1200_000D);
    wr("R4", 2, 1'b0, 14, 32'h1200_000E);
    wr("R4", 3, 1'b0, 13, 32'h5300_000D);
    wr("R4", 3, 1'b0, 14, 32'h5300_000E);
    wr("R4", 2, 1'b0, 12, 32'h1212_000C);
    rd("R4", 3, 1'b0, 12, 13);
    rd("R4", 2, 1'b0, 14, 13);
    rd("R4", 0, 1'b0, 13, 14);

    // R5: force-user from interrupt/supervisor reaches user R13/R14
    rd("R5", 3, 1'b1, 13, 14);
    wr("R5", 3, 1'b1, 14, 32'h5555_00EE);
    wr("R5", 2, 1'b1, 13, 32'h5555_00DD);
    rd("R5", 0, 1'b0, 13, 14);
    rd("R5", 3, 1'b0, 13, 14);
    rd("R5", 2, 1'b1, 12, 14);

    // R6: force-user from fast-interrupt reaches user R8..R14
    rd("R6", 1, 1'b1, 9, 14);
    wr("R6", 1, 1'b1, 10, 32'h6666_000A);
    wr("R6", 1, 1'b1, 8, 32'h6666_0008);
    rd("R6", 0, 1'b0, 10, 8);
    rd("R6", 1, 1'b0, 10, 8);

    // R7: banks survive a tour of every mode
    for (int m = 0; m < 4; m++) rd("R7", m, 1'b0, 13, 14);
    for (int m = 3; m >= 0; m--) rd("R7", m, 1'b0, 8, 14);

    // R8: mode changes every cycle, reads follow immediately
    for (int k = 0; k < 8; k++) rd("R8", k % 4, 1'b0, 13, 9);

    // R9: same-cycle read of the register being written gives the old value
    cyc("R9", 2, 1'b0, 13, 12, 1'b1, 13, 32'h9999_0013);
    rd("R9", 2, 1'b0, 13, 13);
    cyc("R9", 1, 1'b0, 11, 11, 1'b1, 11, 32'h9999_0011);
    rd("R9", 1, 1'b0, 11, 0);

    // R10: address 15 reads zero and a write to it lands nowhere
    cyc("R10", 0, 1'b0, 15, 14, 1'b1, 15, 32'hDEAD_BEEF);
    for (int m = 0; m < 4; m++) rd("R10", m, 1'b0, 15, 14);
    for (int a = 0; a < 15; a++) rd("R10", 0, 1'b0, a, 15);

    // R11: independent ports under a mixed pseudo-random load
    for (int k = 0; k < 600; k++) begin
      int m  = int'($urandom_range(3, 0));
      bit fu = 1'($urandom_range(1, 0));
      int ra = int'($urandom_range(15, 0));
      int rb = (k % 5 == 0) ? ra : int'($urandom_range(15, 0));
      bit we = 1'($urandom_range(1, 0));
      int wa = (k % 3 == 0) ? ra : int'($urandom_range(15, 0));
      cyc("R11", m, fu, ra, rb, we, wa, $urandom());
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule